// File: doc/BRIEF.md
# Synchronizable Integer Clock Divider

This block divides its input clock by a programmable whole number N between 1 and 8. It produces two outputs. The first is a one-cycle enable pulse that marks the last input cycle of each divided period. The second is a divided clock level. A third output, the duty-correction request, tells downstream clocking logic that the divided waveform is not guaranteed to be symmetric. It is raised for every ratio other than 1.

Several copies of the divider can be phase-aligned with a shared, asynchronous sync line. The line is synchronized inside the block and only its rising edge counts. An accepted edge returns the counter to its first phase, so every copy with the same ratio produces the same waveform from then on.

Two control bits set how the sync line is used:
- **Off:** the line is ignored.
- **Every edge:** each rising edge realigns the counter.
- **Once:** only the first rising edge after a control-register write realigns the counter.

The control register is a plain parallel write port with a one-cycle write strobe.

Top module: `clkdiv_sync`

## Requirements
- R1: After reset the ratio field is 0 (divide by 1) and sync handling is off. The outputs are then `div_ce`=1, `div_clk`=0 and `dcs_req`=0.
- R2: The ratio field holds N-1, so field value 0 gives N=1 and field value 7 gives N=8. `div_ce` is high for exactly one cycle in every N cycles, in the last cycle of the period (phase N-1).
- R3: Phase 0 is the first cycle of the period. `div_clk` is high from phase 0 for floor(N/2) cycles and low for the rest of the period. At N=1 it stays low.
- R4: `dcs_req` is 1 exactly when the most recently written ratio field is nonzero. It takes the new value in the cycle after the write.
- R5: `sync_in` passes through a two-stage synchronizer. Only a rising edge forms a sync event. Suppose the third rising clock edge that samples `sync_in` high accepts the event. In the cycle after that edge the divider is at phase 0. Holding `sync_in` high causes no further realignment.
- R6: With `cfg_sync_en`=0, sync events have no effect on the outputs.
- R7: With `cfg_sync_en`=1 and `cfg_sync_once`=0, every sync event realigns the divider to phase 0.
- R8: With `cfg_sync_en`=1 and `cfg_sync_once`=1, only the first sync event after a control write realigns the divider. Later events are ignored until the next write. Every write re-arms this, whatever bits it carries.
- R9: A newly written ratio takes effect at the next period wrap (after the cycle with `div_ce`=1) or at the next accepted sync event, whichever comes first. The period in progress is never cut short or lengthened.
- R10: At N=1, `div_ce` is high in every cycle, including cycles around an accepted sync event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | One-cycle control write strobe |
| cfg_ratio | input | RATIO_W | Ratio field, N-1 |
| cfg_sync_en | input | 1 | Enables sync-based realignment |
| cfg_sync_once | input | 1 | 1: only first sync after a write; 0: every sync |
| sync_in | input | 1 | Asynchronous alignment request |
| div_ce | output | 1 | One-cycle pulse at the last phase of each period |
| div_clk | output | 1 | Divided clock level |
| dcs_req | output | 1 | Duty-correction request, high when N is not 1 |

## Verification
A wrong counter or active-ratio value shows up at the ports within one divided period, at most eight cycles. It appears as a misplaced `div_ce` pulse or a wrongly timed `div_clk` edge.

A wrong armed flag or a wrong sync-mode decode stays hidden until the next sync event. That event then either realigns a divider that should have held its phase, or fails to realign one that should have. The mismatch becomes visible three cycles after the edge on `sync_in`.

The bench therefore follows each control write with sync pulses that land mid-period, where a realignment always changes the next `div_ce` position.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

   typedef enum logic [1:0] {
      SYNC_OFF   = 2'd0,
      SYNC_EVERY = 2'd1,
      SYNC_ONCE  = 2'd2
   } sync_mode_e;

   function automatic sync_mode_e decode_mode(input logic en, input logic once);
      if (!en)
         return SYNC_OFF;
      else if (once)
         return SYNC_ONCE;
      else
         return SYNC_EVERY;
   endfunction

endpackage

// File: rtl/clkdiv_sync_in.sv
module clkdiv_sync_in #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);
   localparam int CHAIN = STAGES + 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("clkdiv_sync_in: STAGES must be at least 2");
   end

   logic [CHAIN-1:0] chain_q;

   for (genvar i = 0; i < CHAIN; i++) begin : g_chain
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/clkdiv_sync_gate.sv
module clkdiv_sync_gate
   import clkdiv_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_wr,
   input  sync_mode_e mode_i,
   input  logic       rise_i,
   output logic       accept_o,
   output logic       armed_o
);
   logic armed_q;

   always_comb begin
      unique case (mode_i)
         SYNC_EVERY: accept_o = rise_i;
         SYNC_ONCE:  accept_o = rise_i & armed_q;
         default:    accept_o = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         armed_q <= 1'b0;
      else if (cfg_wr)
         armed_q <= 1'b1;
      else if (accept_o && mode_i == SYNC_ONCE)
         armed_q <= 1'b0;
   end

   assign armed_o = armed_q;

endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
   parameter int RATIO_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [RATIO_W-1:0] ratio_i,
   input  logic               restart_i,
   output logic [RATIO_W-1:0] cnt_o,
   output logic [RATIO_W-1:0] act_o,
   output logic               ce_o,
   output logic               clk_o
);
   localparam int HW = RATIO_W + 1;

   logic [RATIO_W-1:0] cnt_q;
   logic [RATIO_W-1:0] act_q;
   logic               wrap;
   logic [HW-1:0]      hi_len;

   assign wrap   = (cnt_q == act_q);
   assign hi_len = ({1'b0, act_q} + HW'(1)) >> 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         act_q <= '0;
      end else if (restart_i || wrap) begin
         cnt_q <= '0;
         act_q <= ratio_i;
      end else begin
         cnt_q <= cnt_q + RATIO_W'(1);
      end
   end

   assign cnt_o = cnt_q;
   assign act_o = act_q;
   assign ce_o  = wrap;
   assign clk_o = ({1'b0, cnt_q} < hi_len);

endmodule

// File: rtl/clkdiv_sync.sv
module clkdiv_sync
   import clkdiv_pkg::*;
#(
   parameter int RATIO_W     = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_wr,
   input  logic [RATIO_W-1:0] cfg_ratio,
   input  logic               cfg_sync_en,
   input  logic               cfg_sync_once,
   input  logic               sync_in,
   output logic               div_ce,
   output logic               div_clk,
   output logic               dcs_req
);
   if (RATIO_W < 1) begin : g_bad_width
      $error("clkdiv_sync: RATIO_W must be at least 1");
   end

   logic [RATIO_W-1:0] ratio_q;
   logic               en_q;
   logic               once_q;
   sync_mode_e         mode;
   logic               rise;
   logic               accept;
   logic               armed;
   logic [RATIO_W-1:0] cnt;
   logic [RATIO_W-1:0] act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ratio_q <= '0;
         en_q    <= 1'b0;
         once_q  <= 1'b0;
      end else if (cfg_wr) begin
         ratio_q <= cfg_ratio;
         en_q    <= cfg_sync_en;
         once_q  <= cfg_sync_once;
      end
   end

   assign mode    = decode_mode(en_q, once_q);
   assign dcs_req = (ratio_q != '0);

   clkdiv_sync_in #(.STAGES(SYNC_STAGES)) u_sync_in (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (sync_in),
      .rise_o  (rise)
   );

   clkdiv_sync_gate u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_wr   (cfg_wr),
      .mode_i   (mode),
      .rise_i   (rise),
      .accept_o (accept),
      .armed_o  (armed)
   );

   clkdiv_counter #(.RATIO_W(RATIO_W)) u_counter (
      .clk       (clk),
      .rst_n     (rst_n),
      .ratio_i   (ratio_q),
      .restart_i (accept),
      .cnt_o     (cnt),
      .act_o     (act),
      .ce_o      (div_ce),
      .clk_o     (div_clk)
   );

endmodule

// File: rtl/clkdiv_sync_chk.sv
module clkdiv_sync_chk #(
   parameter int RATIO_W = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_wr,
   input logic [RATIO_W-1:0] cfg_ratio,
   input logic               dcs_req,
   input logic               div_ce,
   input logic               accept,
   input logic               once_q,
   input logic               en_q,
   input logic               armed,
   input logic [RATIO_W-1:0] cnt,
   input logic [RATIO_W-1:0] act
);
   logic past_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R4: duty-correction request tracks the last written field
   a_r4_dcs_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(cfg_wr)) |-> (dcs_req == ($past(cfg_ratio) != '0)));

   // R5: an accepted event puts the counter at phase 0
   a_r5_sync_zero: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (cnt == '0));

   // R2: the counter never passes the active period length
   a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= act);

   // R2: the pulse is followed by the first phase
   a_r2_ce_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      div_ce |=> (cnt == '0));

   // R8: the armed flag is spent by the first accepted event
   a_r8_once_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && en_q && once_q && !cfg_wr) |=> !armed);

   // R9: the active ratio changes only at a wrap or an accepted event
   a_r9_act_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!div_ce && !accept) |=> $stable(act));

endmodule

bind clkdiv_sync clkdiv_sync_chk #(.RATIO_W(RATIO_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_wr    (cfg_wr),
   .cfg_ratio (cfg_ratio),
   .dcs_req   (dcs_req),
   .div_ce    (div_ce),
   .accept    (accept),
   .once_q    (once_q),
   .en_q      (en_q),
   .armed     (armed),
   .cnt       (cnt),
   .act       (act)
);

// File: tb/test_clkdiv_sync.sv
module test_clkdiv_sync;
   localparam int CLK_P = 10;
   localparam int RW    = 3;

   typedef struct packed {
      logic ce;
      logic ck;
      logic dcs;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [RW-1:0] cfg_ratio = '0;
   logic          cfg_sync_en = 1'b0;
   logic          cfg_sync_once = 1'b0;
   logic          sync_in = 1'b0;
   logic          div_ce, div_clk, dcs_req;

   int     n_run = 0;
   int     n_fail = 0;
   string  cur_req = "R1";
   exp_t   sb_q[$];
   logic   done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   clkdiv_sync #(.RATIO_W(RW), .SYNC_STAGES(2)) i_clkdiv_sync (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_wr        (cfg_wr),
      .cfg_ratio     (cfg_ratio),
      .cfg_sync_en   (cfg_sync_en),
      .cfg_sync_once (cfg_sync_once),
      .sync_in       (sync_in),
      .div_ce        (div_ce),
      .div_clk       (div_clk),
      .dcs_req       (dcs_req)
   );

   // Expected-behaviour model, written from the requirements
   logic [2:0]    m_s = '0;
   logic [RW-1:0] m_ratio = '0, m_cnt = '0, m_act = '0;
   logic          m_en = 1'b0, m_once = 1'b0, m_arm = 1'b0;

   always @(posedge clk) begin
      logic rise, acc;
      exp_t it;
      if (!rst_n) begin
         m_s = '0; m_ratio = '0; m_cnt = '0; m_act = '0;
         m_en = 1'b0; m_once = 1'b0; m_arm = 1'b0;
      end else begin
         rise = m_s[1] & ~m_s[2];
         acc  = rise & m_en & (~m_once | m_arm);
         if (acc || m_cnt == m_act) begin
            m_cnt = '0;
            m_act = m_ratio;
         end else begin
            m_cnt = m_cnt + 1'b1;
         end
         if (cfg_wr)                m_arm = 1'b1;
         else if (acc && m_once)    m_arm = 1'b0;
         if (cfg_wr) begin
            m_ratio = cfg_ratio; m_en = cfg_sync_en; m_once = cfg_sync_once;
         end
         m_s = {m_s[1:0], sync_in};
      end
      it.ce  = (m_cnt == m_act);
      it.ck  = (int'(m_cnt) < (int'(m_act) + 1) / 2);
      it.dcs = (m_ratio != '0);
      sb_q.push_back(it);
   end

   // Monitor: pop and compare away from the active edge
   always @(negedge clk) begin
      exp_t it;
      if (sb_q.size() > 0 && !done) begin
         it = sb_q.pop_front();
         n_run++;
         if ({div_ce, div_clk, dcs_req} !== it) begin
            n_fail++;
            $display("FAIL %s (ce R2, clk R3, dcs R4): got ce=%b clk=%b dcs=%b exp ce=%b clk=%b dcs=%b",
                     cur_req, div_ce, div_clk, dcs_req, it.ce, it.ck, it.dcs);
         end
      end
   end

   task automatic chk(input string req, input logic got, input logic exp, input string what);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, got, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [RW-1:0] r, input logic en, input logic once);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_ratio = r; cfg_sync_en = en; cfg_sync_once = once;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic pulse(input int hi);
      @(negedge clk);
      sync_in = 1'b1;
      cyc(hi);
      sync_in = 1'b0;
   endtask

   initial begin
      cyc(3);
      // R1: reset state
      chk("R1", div_ce, 1'b1, "div_ce");
      chk("R1", div_clk, 1'b0, "div_clk");
      chk("R1", dcs_req, 1'b0, "dcs_req");
      rst_n = 1'b1;
      cyc(4);

      cur_req = "R2";
      for (int r = 1; r < 8; r++) begin
         wr(RW'(r), 1'b0, 1'b0);
         chk("R4", dcs_req, 1'b1, "dcs_req after write");
         cyc(3 * (r + 1) + 2);
      end

      cur_req = "R6";
      wr(3'd4, 1'b0, 1'b0);
      cyc(7);
      pulse(2); cyc(12);
      pulse(5); cyc(12);

      cur_req = "R5";
      wr(3'd3, 1'b1, 1'b0);
      cyc(2);
      @(negedge clk);
      sync_in = 1'b1;
      cyc(3);
      chk("R5", div_clk, 1'b1, "phase 0 clk");
      chk("R5", div_ce, 1'b0, "phase 0 ce");
      cyc(3);
      chk("R5", div_ce, 1'b1, "phase 3 ce");
      cyc(20);
      sync_in = 1'b0;
      cyc(5);

      cur_req = "R7";
      wr(3'd5, 1'b1, 1'b0);
      for (int k = 0; k < 4; k++) begin
         cyc(k + 2);
         pulse(2);
      end
      cyc(15);

      cur_req = "R8";
      wr(3'd4, 1'b1, 1'b1);
      cyc(3); pulse(1); cyc(7);
      pulse(1); cyc(8);
      pulse(3); cyc(9);
      wr(3'd4, 1'b1, 1'b1);
      cyc(2); pulse(1); cyc(10);
      pulse(1); cyc(10);

      cur_req = "R9";
      wr(3'd7, 1'b0, 1'b0);
      cyc(3);
      wr(3'd1, 1'b0, 1'b0);
      cyc(20);
      wr(3'd6, 1'b1, 1'b0);
      cyc(1);
      wr(3'd2, 1'b1, 1'b0);
      pulse(1);
      cyc(20);

      cur_req = "R10";
      wr(3'd0, 1'b1, 1'b0);
      cyc(10);
      chk("R4", dcs_req, 1'b0, "dcs_req at N=1");
      pulse(2);
      for (int k = 0; k < 6; k++) begin
         cyc(1);
         chk("R10", div_ce, 1'b1, "ce at N=1");
         chk("R3", div_clk, 1'b0, "clk at N=1");
      end
      wr(3'd0, 1'b1, 1'b1);
      pulse(1); cyc(8);

      cyc(2);
      done = 1'b1;
      if (sb_q.size() > 1) begin
         n_run++; n_fail++;
         $display("FAIL R2 scoreboard backlog: actual=%0d expected<=1", sb_q.size());
      end
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL %s watchdog: actual=timeout expected=completion", cur_req);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule